// File: doc/BRIEF.md
# Converter Start-up Output Sequencer

This block decides when a data converter's digital output may carry real samples. It watches an active-low supply-good indication (`por_n`), an active-low power-down request (`pdn_n`), the system clock and a one-cycle frame tick that marks each sample period. From these it drives an internal reset for the datapath, a clock enable for that datapath, a select that forces the serial data line to zero, an output-driver enable and a two-bit phase code.

Start-up has two stages. A fixed number of system clocks (`RST_CYCLES`, 1024 by default) pass with the datapath held in reset. A fixed number of frame ticks (`MUTE_FRAMES`, 4480 by default) then pass with the datapath running but its output replaced by zeros. Only after both does the output carry conversion results. A power-down request stops the datapath clock and the output driver from any phase. Leaving power-down runs the whole start-up again. Sampling rate, format and oversampling settings held elsewhere should only be changed while power-down is requested.

The controller has four states: `SEQ_HOLD` (reset held, clocks counted), `SEQ_MUTE` (reset released, frames counted, zeros sent), `SEQ_RUN` (data valid) and `SEQ_PDN` (powered down). The transitions are:
- `por_n` low moves any state to `SEQ_HOLD` at once, without waiting for a clock edge.
- `pdn_n` low moves any state to `SEQ_PDN`.
- `SEQ_HOLD` moves to `SEQ_MUTE` when the clock count completes.
- `SEQ_MUTE` moves to `SEQ_RUN` on the frame tick that completes the frame count.
- `SEQ_PDN` moves to `SEQ_HOLD` once `pdn_n` is high.
- `SEQ_RUN` stays in `SEQ_RUN` otherwise.

Top module: `conv_start_seq`

## Requirements
- R1: While `por_n` is low, `core_rst`=1, `dout_zero`=1 and `phase`=0. The phase codes are 0 reset-hold, 1 muted, 2 running and 3 powered-down.
- R2: After `por_n` rises with `pdn_n` high, `core_rst` stays 1 for exactly `RST_CYCLES` clock cycles and then falls, with `phase` going from 0 to 1.
- R3: In the muted phase, `dout_zero` stays 1. On the clock edge that samples the `MUTE_FRAMES`-th high `frame_tick` of that phase, `phase` becomes 2 and `dout_zero` becomes 0.
- R4: Frame ticks sampled during the reset-hold phase are not counted toward `MUTE_FRAMES`.
- R5: In the running phase, with `por_n` and `pdn_n` high, the outputs stay at `core_rst`=0, `dout_zero`=0, `dp_clk_en`=1, `dout_en`=1 and `phase`=2, whatever `frame_tick` does.
- R6: When `pdn_n` is sampled low at a clock edge in any phase, from the next cycle on `phase`=3, `dp_clk_en`=0, `dout_en`=0, `core_rst`=1 and `dout_zero`=1.
- R7: Frame ticks during power-down have no effect. Once `pdn_n` is high, the next edge enters reset-hold, and the full sequence repeats: `RST_CYCLES` clocks, then `MUTE_FRAMES` ticks.
- R8: A low `por_n` forces `phase`=0 and `core_rst`=1 immediately, without a clock edge, from any phase. It takes priority over a low `pdn_n`.
- R9: In the reset-hold and muted phases, `dp_clk_en`=1 and `dout_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| por_n | input | 1 | Supply-good; low holds the block in reset (asynchronous) |
| pdn_n | input | 1 | Power-down request, active low |
| frame_tick | input | 1 | One-cycle pulse per sample period |
| core_rst | output | 1 | Reset for the converter datapath, active high |
| dp_clk_en | output | 1 | Clock enable for the datapath |
| dout_zero | output | 1 | Forces the serial data line to zero |
| dout_en | output | 1 | Serial output driver enable |
| phase | output | 2 | 0 reset-hold, 1 muted, 2 running, 3 powered-down |

## Verification
A wrong state code appears on `phase` and on the four control outputs in the same cycle, because all outputs are decoded directly from the state register. A clock or frame counter that is off by one moves the fall of `core_rst` or the fall of `dout_zero` by a single cycle or a single frame. A reference model compared on every clock catches that shift at the first cycle where it differs. A power-down that is missed or does not restart shows up one cycle after `pdn_n` is sampled low, through `dp_clk_en`. A wrong restart shows up in the length of the following reset-hold phase.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    // Phase encoding is visible on the phase port: keep values fixed.
    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_MUTE = 2'd1,
        SEQ_RUN  = 2'd2,
        SEQ_PDN  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic       core_rst;
        logic       dp_clk_en;
        logic       dout_zero;
        logic       dout_en;
        logic [1:0] phase;
    } seq_ctrl_t;

endpackage

// File: rtl/conv_seq_count.sv
// Saturating up-counter with synchronous clear; flags the final count value.
module conv_seq_count #(
    parameter int LIMIT = 1024
) (
    input  logic sys_clk,
    input  logic arst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge sys_clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == LAST);

endmodule

// File: rtl/conv_seq_decode.sv
// Moore output decode for the start-up sequencer.
module conv_seq_decode
    import conv_seq_pkg::*;
(
    input  seq_state_t state,
    output seq_ctrl_t  ctrl
);
    always_comb begin
        ctrl = '{core_rst: 1'b1, dp_clk_en: 1'b1, dout_zero: 1'b1,
                 dout_en: 1'b1, phase: state};
        unique case (state)
            SEQ_HOLD: begin
                ctrl.core_rst  = 1'b1;
                ctrl.dout_zero = 1'b1;
            end
            SEQ_MUTE: begin
                ctrl.core_rst  = 1'b0;
                ctrl.dout_zero = 1'b1;
            end
            SEQ_RUN: begin
                ctrl.core_rst  = 1'b0;
                ctrl.dout_zero = 1'b0;
            end
            SEQ_PDN: begin
                ctrl.core_rst  = 1'b1;
                ctrl.dp_clk_en = 1'b0;
                ctrl.dout_zero = 1'b1;
                ctrl.dout_en   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/conv_start_seq.sv
module conv_start_seq
    import conv_seq_pkg::*;
#(
    parameter int RST_CYCLES  = 1024,
    parameter int MUTE_FRAMES = 4480
) (
    input  logic       sys_clk,
    input  logic       por_n,
    input  logic       pdn_n,
    input  logic       frame_tick,
    output logic       core_rst,
    output logic       dp_clk_en,
    output logic       dout_zero,
    output logic       dout_en,
    output logic [1:0] phase
);
    seq_state_t state, state_nx;
    seq_ctrl_t  ctrl;
    logic       hold_last, mute_last;
    logic       hold_inc, hold_clr, mute_inc, mute_clr;

    // Clock counter for the reset-hold stage.
    assign hold_inc = (state == SEQ_HOLD);
    assign hold_clr = (state != SEQ_HOLD);

    conv_seq_count #(.LIMIT(RST_CYCLES)) u_hold_cnt (
        .sys_clk (sys_clk),
        .arst_n  (por_n),
        .clr     (hold_clr),
        .inc     (hold_inc),
        .at_last (hold_last)
    );

    // Frame counter for the muted stage.
    assign mute_inc = (state == SEQ_MUTE) && frame_tick;
    assign mute_clr = (state != SEQ_MUTE);

    conv_seq_count #(.LIMIT(MUTE_FRAMES)) u_mute_cnt (
        .sys_clk (sys_clk),
        .arst_n  (por_n),
        .clr     (mute_clr),
        .inc     (mute_inc),
        .at_last (mute_last)
    );

    // State register.
    always_ff @(posedge sys_clk or negedge por_n) begin
        if (!por_n) state <= SEQ_HOLD;
        else        state <= state_nx;
    end

    // Next-state logic; power-down dominates every state.
    always_comb begin
        state_nx = state;
        if (!pdn_n) begin
            state_nx = SEQ_PDN;
        end else begin
            unique case (state)
                SEQ_HOLD: if (hold_last)              state_nx = SEQ_MUTE;
                SEQ_MUTE: if (frame_tick && mute_last) state_nx = SEQ_RUN;
                SEQ_RUN:                              state_nx = SEQ_RUN;
                SEQ_PDN:                              state_nx = SEQ_HOLD;
            endcase
        end
    end

    conv_seq_decode u_decode (
        .state (state),
        .ctrl  (ctrl)
    );

    assign core_rst  = ctrl.core_rst;
    assign dp_clk_en = ctrl.dp_clk_en;
    assign dout_zero = ctrl.dout_zero;
    assign dout_en   = ctrl.dout_en;
    assign phase     = ctrl.phase;

    // ---------------- checks ----------------
    // Independent stage-length counters for the window checks.
    logic [31:0] chk_hold_len, chk_mute_ticks;

    always_ff @(posedge sys_clk or negedge por_n) begin
        if (!por_n) begin
            chk_hold_len   <= '0;
            chk_mute_ticks <= '0;
        end else begin
            chk_hold_len   <= (phase == 2'd0) ? chk_hold_len + 1 : '0;
            chk_mute_ticks <= (phase == 2'd1) ? chk_mute_ticks + 32'(frame_tick) : '0;
        end
    end

    assert_hold_len_R2: assert property (@(posedge sys_clk) disable iff (!por_n)
        (phase == 2'd1 && $past(phase) == 2'd0) |-> (chk_hold_len == 32'(RST_CYCLES)));

    assert_mute_len_R3: assert property (@(posedge sys_clk) disable iff (!por_n)
        (phase == 2'd2 && $past(phase) == 2'd1) |-> (chk_mute_ticks == 32'(MUTE_FRAMES)));

    assert_run_hold_R5: assert property (@(posedge sys_clk) disable iff (!por_n)
        (phase == 2'd2 && pdn_n) |=> (phase == 2'd2 && !dout_zero));

    assert_pdn_entry_R6: assert property (@(posedge sys_clk) disable iff (!por_n)
        !pdn_n |=> (phase == 2'd3 && !dp_clk_en && !dout_en));

    assert_pdn_exit_R7: assert property (@(posedge sys_clk) disable iff (!por_n)
        (phase == 2'd3 && pdn_n) |=> (phase == 2'd0 && core_rst));

    assert_gated_safe_R6: assert property (@(posedge sys_clk) disable iff (!por_n)
        !dp_clk_en |-> (core_rst && dout_zero));

    assert_clk_live_R9: assert property (@(posedge sys_clk) disable iff (!por_n)
        (phase == 2'd0 || phase == 2'd1) |-> (dp_clk_en && dout_en));

endmodule

// File: tb/conv_start_seq_test.sv
module conv_start_seq_test;
    localparam int RST_N  = 1024;
    localparam int MUTE_N = 4480;
    localparam int WDOG   = 150000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic por_n = 1'b0, pdn_n = 1'b1, frame_tick = 1'b0;
    logic core_rst, dp_clk_en, dout_zero, dout_en;
    logic [1:0] phase;

    conv_start_seq #(.RST_CYCLES(RST_N), .MUTE_FRAMES(MUTE_N)) uut (
        .sys_clk(clk), .por_n(por_n), .pdn_n(pdn_n), .frame_tick(frame_tick),
        .core_rst(core_rst), .dp_clk_en(dp_clk_en), .dout_zero(dout_zero),
        .dout_en(dout_en), .phase(phase)
    );

    int n_chk = 0, n_err = 0, cyc = 0, tick_div = 2;
    int n_hold = 0, n_mticks = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Frame tick source, driven just after each rising edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        frame_tick = (cyc % tick_div == 0);
    end

    // Reference model: 0 hold, 1 muted, 2 running, 3 powered down.
    int m_st = 0, m_hc = 0, m_fc = 0;
    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_st = 0; m_hc = 0; m_fc = 0;
        end else if (!pdn_n) begin
            m_st = 3;
        end else begin
            case (m_st)
                0: begin
                    m_hc++;
                    if (m_hc == RST_N) begin m_st = 1; m_fc = 0; end
                end
                1: if (frame_tick) begin
                    m_fc++;
                    if (m_fc == MUTE_N) m_st = 2;
                end
                2: ;
                default: begin m_st = 0; m_hc = 0; end
            endcase
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            int exp_v, got_v;
            string tag;
            exp_v = {m_st[1:0], (m_st == 0 || m_st == 3), (m_st != 2),
                     (m_st != 3), (m_st != 3)};
            got_v = {phase, core_rst, dout_zero, dp_clk_en, dout_en};
            if (!por_n)         tag = "R1 R8";
            else if (m_st == 0) tag = "R2 R9";
            else if (m_st == 1) tag = "R3 R4 R9";
            else if (m_st == 2) tag = "R5";
            else                tag = "R6 R7";
            check(got_v == exp_v, tag, "per-cycle outputs", got_v, exp_v);
            if (por_n && core_rst && dp_clk_en) n_hold++;
            if (phase == 2'd1 && frame_tick)    n_mticks++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_phase(input logic [1:0] p);
        while (phase != p) @(negedge clk);
    endtask

    initial begin
        // Reset held by supply-good low.
        step(4);
        @(negedge clk);
        check(core_rst == 1'b1 && dout_zero == 1'b1, "R1", "rst/zero in por", {core_rst, dout_zero}, 3);
        check(phase == 2'd0, "R1", "phase in por", phase, 0);
        pdn_n = 1'b0;
        step(3);
        @(negedge clk);
        check(phase == 2'd0, "R8", "por over power-down", phase, 0);
        pdn_n = 1'b1;

        // First start-up; ticks already running during hold.
        step(1);
        n_hold = 0; n_mticks = 0;
        por_n = 1'b1;
        wait_phase(2'd2);
        check(n_hold == RST_N, "R2", "hold cycles", n_hold, RST_N);
        check(n_mticks == MUTE_N, "R4", "muted ticks counted", n_mticks, MUTE_N);
        check(dout_zero == 1'b0, "R3", "zero released", dout_zero, 0);

        step(50);
        @(negedge clk);
        check(phase == 2'd2 && !core_rst && !dout_zero, "R5", "run steady", phase, 2);

        // Power-down from running.
        step(1);
        pdn_n = 1'b0;
        @(negedge clk);
        check(phase == 2'd2, "R6", "before sampling", phase, 2);
        @(negedge clk);
        check(phase == 2'd3, "R6", "phase after pdn", phase, 3);
        check(!dp_clk_en && !dout_en, "R6", "gated outputs", {dp_clk_en, dout_en}, 0);
        step(100);
        @(negedge clk);
        check(phase == 2'd3, "R7", "ticks ignored in pdn", phase, 3);
        tick_div = 3;
        step(1);
        n_hold = 0; n_mticks = 0;
        pdn_n = 1'b1;
        wait_phase(2'd2);
        check(n_hold == RST_N, "R7", "restart hold cycles", n_hold, RST_N);
        check(n_mticks == MUTE_N, "R7", "restart muted ticks", n_mticks, MUTE_N);

        // Asynchronous supply drop while running.
        step(5);
        por_n = 1'b0;
        #1;
        check(phase == 2'd0 && core_rst, "R8", "async reset", phase, 0);
        tick_div = 2;
        step(3);
        por_n = 1'b1;
        wait_phase(2'd1);
        step(200);
        pdn_n = 1'b0;
        step(1);
        @(negedge clk);
        check(phase == 2'd3, "R6", "pdn from muted", phase, 3);
        step(10);
        pdn_n = 1'b1;
        step(100);
        @(negedge clk);
        check(phase == 2'd0, "R7", "hold after pdn release", phase, 0);
        step(1);
        pdn_n = 1'b0;
        step(1);
        @(negedge clk);
        check(phase == 2'd3, "R6", "pdn from hold", phase, 3);
        step(5);
        n_hold = 0; n_mticks = 0;
        pdn_n = 1'b1;
        wait_phase(2'd2);
        check(n_hold == RST_N, "R2", "hold cycles again", n_hold, RST_N);
        check(n_mticks == MUTE_N, "R3", "muted ticks again", n_mticks, MUTE_N);
        step(20);
        @(negedge clk);
        check(dp_clk_en && dout_en && !core_rst, "R5", "final run", {dp_clk_en, dout_en, core_rst}, 6);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cyc > WDOG) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WDOG);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule